// File: doc/BRIEF.md
# ISA Master Memory Forwarding Decoder

This block decides, for each memory cycle started by an ISA DMA channel or an ISA bus master, whether its 24-bit address is passed on to the PCI side or stays on the local ISA side. A small byte-wide configuration port holds the settings. Each request is marked by an address strobe and gets a registered yes/no answer one clock later.

An address is forwarded only when three tests all pass:

- It lies below a programmable top-of-memory limit. The limit runs from 1 MB to 16 MB in 1 MB steps, with an optional extra 512K.
- It is outside a programmable hole. The hole is defined on address bits 23:16 and switches itself off when its bounds are not in ascending order.
- If it is below 1 MB, the enable bit of its legacy region is set. The C0000–DFFFF area is split into eight 16K segments, each with its own enable bit.

Configuration map (byte offsets on `cfg_addr`):

| Offset | Contents |
|---|---|
| 0 | Hole bottom |
| 1 | Hole top |
| 2 | Window enables 7:0 |
| 3 | Window enables 15:8 |
| 4 | Bit 0 is the +512K control |

Top module: `isa_fwd_decoder`

## Requirements
- R1: After reset the configuration reads back as follows: offset 0 = 0x00, offset 1 = 0x00, offset 2 = 0x00, offset 3 = 0x03, offset 4 = 0x01. Outputs `rsp_valid` and `rsp_fwd` are low.
- R2: A write is visible on `cfg_rdata` from the next cycle. Each register returns the value last written. Offset 4 returns only bit 0, and bits 7:1 read as 0. Offsets 5 to 7 read as 0 and ignore writes.
- R3: `rsp_valid` equals `req_valid` delayed by one clock. `rsp_fwd` is low whenever `rsp_valid` is low.
- R4: The window register holds the top-of-memory code T in bits 15:12. With offset 4 bit 0 = P, the limit is (T+1) MB + P·512K. An address equal to or above the limit is never forwarded.
- R5: When hole top > hole bottom, an address whose bits 23:16 are ≥ bottom and ≤ top is not forwarded. When hole top ≤ hole bottom, the hole has no effect.
- R6: Below 1 MB, each region is forwarded only if its window bit is set:
  - 00000–7FFFF uses bit 8.
  - 80000–9FFFF uses bit 9.
  - A0000–BFFFF uses bit 10.
  - E0000–EFFFF uses bit 11.
- R7: In C0000–DFFFF, the 16K segment with index (address − C0000) / 4000h is forwarded only if window bit [index] is set (bits 0 to 7).
- R8: Addresses in F0000–FFFFF are never forwarded.
- R9: An address at or above 1 MB, below the limit and outside an active hole, is forwarded whatever the window bits 11:0 are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| req_valid | input | 1 | ISA master memory request strobe |
| req_addr | input | 24 | ISA master memory address |
| rsp_valid | output | 1 | Decision valid, one clock after the request |
| rsp_fwd | output | 1 | 1 = forward to PCI, 0 = keep local |

## Verification
The assertions judge each decision against the configuration seen in the same cycle as the request. They also expect `req_valid` to stay low until the internal reset release has finished. The stimulus follows both rules. It changes registers only between requests, and it waits several clocks after reset before the first strobe. Each sweep steps through every 16K boundary and its last byte across the whole 16 MB space, under configurations that move the limit, open, close and invert the hole, and flip the window bits.

// File: rtl/isa_fwd_pkg.sv
package isa_fwd_pkg;
  localparam int ADDR_W   = 24;
  localparam int DATA_W   = 8;
  localparam int CFG_AW   = 3;
  localparam int WIN_W    = 16;
  localparam int SEG_N    = 8;
  localparam int SEG_BITS = 14;

  localparam logic [CFG_AW-1:0] OFS_HOLE_LO = 3'd0;
  localparam logic [CFG_AW-1:0] OFS_HOLE_HI = 3'd1;
  localparam logic [CFG_AW-1:0] OFS_WIN_LO  = 3'd2;
  localparam logic [CFG_AW-1:0] OFS_WIN_HI  = 3'd3;
  localparam logic [CFG_AW-1:0] OFS_MISC    = 3'd4;

  localparam logic [WIN_W-1:0] WIN_RST  = 16'h0300;
  localparam logic             PLUS_RST = 1'b1;

  typedef struct packed {
    logic [DATA_W-1:0] hole_lo;
    logic [DATA_W-1:0] hole_hi;
    logic [WIN_W-1:0]  win;
    logic              plus512;
  } fwd_cfg_t;
endpackage

// File: rtl/isa_fwd_cfg.sv
module isa_fwd_cfg
  import isa_fwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output fwd_cfg_t          cfg
);
  fwd_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      case (addr)
        OFS_HOLE_LO: cfg_d.hole_lo   = wdata;
        OFS_HOLE_HI: cfg_d.hole_hi   = wdata;
        OFS_WIN_LO:  cfg_d.win[7:0]  = wdata;
        OFS_WIN_HI:  cfg_d.win[15:8] = wdata;
        OFS_MISC:    cfg_d.plus512   = wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.hole_lo <= '0;
      cfg_q.hole_hi <= '0;
      cfg_q.win     <= WIN_RST;
      cfg_q.plus512 <= PLUS_RST;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    case (addr)
      OFS_HOLE_LO: rdata = cfg_q.hole_lo;
      OFS_HOLE_HI: rdata = cfg_q.hole_hi;
      OFS_WIN_LO:  rdata = cfg_q.win[7:0];
      OFS_WIN_HI:  rdata = cfg_q.win[15:8];
      OFS_MISC:    rdata = {{(DATA_W-1){1'b0}}, cfg_q.plus512};
      default:     rdata = '0;
    endcase
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/isa_fwd_limit.sv
module isa_fwd_limit
  import isa_fwd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        top_code,
  input  logic              plus512,
  input  logic [DATA_W-1:0] hole_lo,
  input  logic [DATA_W-1:0] hole_hi,
  output logic              below_top,
  output logic              in_hole
);
  localparam int LIM_W = ADDR_W + 1;

  logic [LIM_W-1:0] limit;
  logic [4:0]       mb_count;
  logic [DATA_W-1:0] page;
  logic             hole_on;

  always_comb begin
    mb_count  = {1'b0, top_code} + 5'd1;
    limit     = {mb_count, 20'h00000} + (plus512 ? LIM_W'('h80000) : '0);
    below_top = {1'b0, addr} < limit;
    page      = addr[ADDR_W-1:ADDR_W-DATA_W];
    hole_on   = hole_hi > hole_lo;
    in_hole   = hole_on && (page >= hole_lo) && (page <= hole_hi);
  end
endmodule

// File: rtl/isa_fwd_legacy.sv
module isa_fwd_legacy
  import isa_fwd_pkg::*;
(
  input  logic [19:0]      addr,
  input  logic [WIN_W-5:0] win,
  output logic             enable
);
  logic [SEG_N-1:0] seg_hit;
  logic             in_seg_area;

  assign in_seg_area = (addr[19:17] == 3'b110);

  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    assign seg_hit[s] = in_seg_area && (addr[16:SEG_BITS] == 3'(s)) && win[s];
  end

  always_comb begin
    enable = 1'b0;
    if (!addr[19])                    enable = win[8];
    else if (addr[19:17] == 3'b100)   enable = win[9];
    else if (addr[19:17] == 3'b101)   enable = win[10];
    else if (in_seg_area)             enable = |seg_hit;
    else if (addr[19:16] == 4'hE)     enable = win[11];
    else                              enable = 1'b0;
  end
endmodule

// File: rtl/isa_fwd_decoder.sv
module isa_fwd_decoder
  import isa_fwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_fwd
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  fwd_cfg_t   cfg;
  logic       below_top, in_hole, legacy_en, low_mb;
  logic       fwd_d, valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  isa_fwd_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  isa_fwd_limit u_limit (
    .addr      (req_addr),
    .top_code  (cfg.win[15:12]),
    .plus512   (cfg.plus512),
    .hole_lo   (cfg.hole_lo),
    .hole_hi   (cfg.hole_hi),
    .below_top (below_top),
    .in_hole   (in_hole)
  );

  isa_fwd_legacy u_legacy (
    .addr   (req_addr[19:0]),
    .win    (cfg.win[11:0]),
    .enable (legacy_en)
  );

  always_comb begin
    low_mb  = (req_addr[ADDR_W-1:20] == '0);
    valid_d = req_valid;
    fwd_d   = req_valid && below_top && !in_hole && (!low_mb || legacy_en);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_fwd   <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      rsp_fwd   <= fwd_d;
    end
  end
endmodule

// File: rtl/isa_fwd_decoder_chk.sv
module isa_fwd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [23:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_fwd,
  input logic [3:0]  top_code,
  input logic        plus512,
  input logic [7:0]  hole_lo,
  input logic [7:0]  hole_hi
);
  // limit expressed in 512K units
  logic [5:0] lim_half;
  assign lim_half = ({2'b00, top_code} + 6'd1) * 6'd2 + {5'd0, plus512};

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fwd));

  p_top_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ({1'b0, req_addr[23:19]} >= lim_half)) |=> !rsp_fwd);

  p_hole_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (hole_hi > hole_lo) && (req_addr[23:16] >= hole_lo)
     && (req_addr[23:16] <= hole_hi)) |=> !rsp_fwd);

  p_f_seg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr[23:16] == 8'h0F)) |=> !rsp_fwd);
endmodule

bind isa_fwd_decoder isa_fwd_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_fwd   (rsp_fwd),
  .top_code  (cfg.win[15:12]),
  .plus512   (cfg.plus512),
  .hole_lo   (cfg.hole_lo),
  .hole_hi   (cfg.hole_hi)
);

// File: tb/isa_fwd_decoder_tb.sv
module isa_fwd_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [7:0]  cfg_wdata = 8'd0;
  logic [7:0]  cfg_rdata;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = 24'd0;
  logic        rsp_valid, rsp_fwd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  m_lo, m_hi;
  logic [15:0] m_win;
  logic        m_plus;

  always #2 clk = ~clk;

  isa_fwd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_fwd(rsp_fwd)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%0h expected=%0h", req, req_addr, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic set_cfg(input logic [7:0] lo, input logic [7:0] hi,
                         input logic [15:0] win, input logic plus);
    wr(3'd0, lo); wr(3'd1, hi); wr(3'd2, win[7:0]); wr(3'd3, win[15:8]);
    wr(3'd4, {7'd0, plus});
    m_lo = lo; m_hi = hi; m_win = win; m_plus = plus;
  endtask

  function automatic int exp_fwd(input int a);
    int limit = (int'(m_win[15:12]) + 1) * 1048576 + (m_plus ? 524288 : 0);
    int pg = a / 65536;
    if (a >= limit) return 0;
    if (m_hi > m_lo && pg >= m_lo && pg <= m_hi) return 0;
    if (a < 'h80000) return m_win[8];
    if (a < 'hA0000) return m_win[9];
    if (a < 'hC0000) return m_win[10];
    if (a < 'hE0000) return m_win[(a - 'hC0000) / 'h4000];
    if (a < 'hF0000) return m_win[11];
    if (a < 'h100000) return 0;
    return 1;
  endfunction

  function automatic string tag(input int a);
    int limit = (int'(m_win[15:12]) + 1) * 1048576 + (m_plus ? 524288 : 0);
    if (a >= limit) return "R4";
    if (m_hi > m_lo && a / 65536 >= m_lo && a / 65536 <= m_hi) return "R5";
    if (a >= 'h100000) return "R9";
    if (a >= 'hF0000) return "R8";
    if (a >= 'hC0000 && a < 'hE0000) return "R7";
    return "R6";
  endfunction

  task automatic probe(input int a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a[23:0];
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 valid", rsp_valid, 1);
    chk(tag(a), rsp_fwd, exp_fwd(a));
  endtask

  task automatic sweep();
    for (int i = 0; i < 1024; i++) begin
      probe(i * 'h4000);
      probe(i * 'h4000 + 'h3FFF);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 rsp_fwd", rsp_fwd, 0);
    rd_chk("R1 hole lo", 3'd0, 8'h00);
    rd_chk("R1 hole hi", 3'd1, 8'h00);
    rd_chk("R1 win lo", 3'd2, 8'h00);
    rd_chk("R1 win hi", 3'd3, 8'h03);
    rd_chk("R1 misc", 3'd4, 8'h01);
    m_lo = 0; m_hi = 0; m_win = 16'h0300; m_plus = 1;
    sweep();
    // R2 readback
    wr(3'd0, 8'hA5); rd_chk("R2 hole lo", 3'd0, 8'hA5);
    wr(3'd1, 8'h5A); rd_chk("R2 hole hi", 3'd1, 8'h5A);
    wr(3'd2, 8'h3C); rd_chk("R2 win lo", 3'd2, 8'h3C);
    wr(3'd3, 8'hC3); rd_chk("R2 win hi", 3'd3, 8'hC3);
    wr(3'd4, 8'hFE); rd_chk("R2 misc bit0 clear", 3'd4, 8'h00);
    wr(3'd4, 8'hFF); rd_chk("R2 misc upper zero", 3'd4, 8'h01);
    wr(3'd5, 8'hFF); rd_chk("R2 unused", 3'd5, 8'h00);
    rd_chk("R2 unused no side effect", 3'd0, 8'hA5);
    // R3 idle
    @(negedge clk);
    chk("R3 idle valid", rsp_valid, 0);
    chk("R3 idle fwd", rsp_fwd, 0);
    // configurations
    set_cfg(8'h00, 8'h00, 16'hFFFF, 1'b0); sweep();
    set_cfg(8'h03, 8'h07, 16'h5A55, 1'b1); sweep();
    set_cfg(8'h20, 8'h20, 16'h7AA0, 1'b0); sweep();
    set_cfg(8'h40, 8'h10, 16'hC6F0, 1'b1); sweep();
    set_cfg(8'h00, 8'h0F, 16'hEFFF, 1'b0); sweep();
    set_cfg(8'h9F, 8'hA0, 16'h2C0F, 1'b1);
    probe('h0A0000 - 1); probe('h0A0000); probe('h9FFFFF); probe('h1FFFFF);
    probe('h200000); probe('h27FFFF); probe('h280000);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule